// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block takes frames from a serial line that rests high. The logic runs on the system clock. A strobe marks every tick of a 16x oversampling clock that is generated elsewhere. A frame begins with a low start bit. The data bits follow, either seven or eight of them, in least-significant-first or most-significant-first order. An extra bit may come next. In normal mode that bit is an optional parity bit. In multiprocessor mode it is an address/data marker. One or two high stop bits close the frame. Every bit is sampled once, near its centre.

A single holding register presents the received byte. A full flag goes high at the first stop bit and stays high until a one-cycle read strobe clears it. Parity and framing error flags describe the most recent frame. A bus-idle flag goes high only once the final stop bit has been seen high. With two stop bits, that point lies one bit period after the full flag. The configuration inputs must stay stable while a frame is in progress.

Top module: `serial_rx_frame`

## Requirements
- R1: A falling edge on the synchronised line while the receiver is idle starts a frame. Every bit, the start bit included, is sampled at the 8th oversample tick of its 16-tick period, counted from the edge.
- R2: If the start bit is high at its mid-bit sample, it is rejected as a glitch. The receiver returns to idle, the full flag does not rise, and bus_idle keeps its value.
- R3: With cfg_eight=1 the frame carries 8 data bits, and with cfg_eight=0 it carries 7. With cfg_msb_first=0 the first data bit on the line is bit 0, and with cfg_msb_first=1 it is the top data bit. In 7-bit mode rx_data[7] is 0.
- R4: In normal mode (cfg_mp_mode=0), cfg_par_en=1 inserts a parity bit after the last data bit. With cfg_par_odd=0, the data bits plus the parity bit hold an even number of ones. With cfg_par_odd=1 they hold an odd number. A mismatch sets err_parity.
- R5: In multiprocessor mode (cfg_mp_mode=1), the bit after the data is always present. Its value appears on rx_addr_flag (1 = address), and err_parity stays 0. In normal mode rx_addr_flag is 0.
- R6: A first stop bit sampled low sets err_frame together with the full flag. When cfg_two_stop=1, a second stop bit sampled low also sets err_frame.
- R7: rx_full and the new rx_data, rx_addr_flag, err_parity and err_frame appear in the cycle after the first stop bit's sample, whatever the stop-bit count. A read strobe clears rx_full unless a new frame sets it in that same cycle.
- R8: bus_idle rises only at the sample of the final stop bit, and only if that bit is high. That final stop bit is the first one when cfg_two_stop=0 and the second when cfg_two_stop=1. bus_idle clears when a start bit is confirmed.
- R9: After reset, rx_full, err_parity and err_frame are 0, rx_data is 0, and bus_idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle strobe, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_par_en | input | 1 | Parity bit present (normal mode) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_mp_mode | input | 1 | 1 = multiprocessor mode (address/data bit) |
| rd_strobe | input | 1 | One-cycle read, clears rx_full |
| rx_data | output | 8 | Received data byte |
| rx_addr_flag | output | 1 | Received address/data bit |
| rx_full | output | 1 | Holding register full |
| err_parity | output | 1 | Parity mismatch on last frame |
| err_frame | output | 1 | Stop bit sampled low on last frame |
| bus_idle | output | 1 | Line idle after the final stop bit |

## Verification
The bench drives asymmetric byte values such as 0xA5, 0x3C and 0x81 under both bit orders and both data widths. A swapped order or an off-by-one assembly index then yields a different byte, and in 7-bit mode a stray top bit becomes visible. Parity is sent correct and corrupted under even and odd settings, so the bench can tell a sense inversion from a missing check. In multiprocessor mode the marker bit is sent as both 1 and 0. The bench compares the bus-idle flag at the moment the full flag rises, once with one stop bit and once with two; this exposes a receiver that waits for the last stop bit before reporting full, or that reports idle too early. A bad first stop bit, a bad second stop bit and a short start glitch each trigger a different error or idle outcome.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP1, ST_STOP2
  } rx_state_e;

  // Put one received bit into the assembly register in the chosen direction.
  function automatic logic [7:0] shift_in(logic [7:0] sh, logic b, logic msb_first);
    return msb_first ? {sh[6:0], b} : {b, sh[7:1]};
  endfunction

  // Turn the assembly register into the output byte; in 7-bit mode the top bit is 0.
  function automatic logic [7:0] align_word(logic [7:0] sh, logic eight, logic msb_first);
    if (msb_first) return eight ? sh : {1'b0, sh[6:0]};
    return eight ? sh : {1'b0, sh[7:1]};
  endfunction

  // The parity bit a correct transmitter would send.
  function automatic logic parity_bit(logic [7:0] word, logic odd);
    return (^word) ^ odd;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rxd};
      prev  <= chain[STAGES-1];
    end
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~line;
endmodule

// File: rtl/rx_os_timer.sv
module rx_os_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic run,
  input  logic restart,
  output logic mid
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (os_tick)          cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
  end

  assign mid = run && os_tick && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic       fall,
  input  logic       mid,
  input  logic       cfg_eight,
  input  logic       cfg_msb_first,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_mp_mode,
  input  logic       rd_strobe,
  output logic       run,
  output logic       restart,
  output logic [7:0] rx_data,
  output logic       rx_addr_flag,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       bus_idle
);
  rx_state_e  state;
  logic [7:0] sh;
  logic [2:0] idx;
  logic       extra;

  logic [7:0] word;
  logic [2:0] last_idx;
  logic       has_extra;
  logic       take_start, glitch, set_full, last_stop_pass;

  assign word       = align_word(sh, cfg_eight, cfg_msb_first);
  assign last_idx   = cfg_eight ? 3'd7 : 3'd6;
  assign has_extra  = cfg_mp_mode | cfg_par_en;
  assign restart    = (state == ST_IDLE) && fall;
  assign run        = (state != ST_IDLE);
  assign take_start = (state == ST_START) && mid && !line;
  assign glitch     = (state == ST_START) && mid && line;
  assign set_full   = (state == ST_STOP1) && mid;
  assign last_stop_pass = mid && line &&
                          (((state == ST_STOP1) && !cfg_two_stop) || (state == ST_STOP2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      sh           <= '0;
      idx          <= '0;
      extra        <= 1'b0;
      rx_data      <= '0;
      rx_addr_flag <= 1'b0;
      rx_full      <= 1'b0;
      err_parity   <= 1'b0;
      err_frame    <= 1'b0;
      bus_idle     <= 1'b1;
    end else begin
      if (rd_strobe) rx_full <= 1'b0;
      case (state)
        ST_IDLE:  if (fall) state <= ST_START;
        ST_START: if (mid) begin
          if (line) state <= ST_IDLE;
          else begin
            state    <= ST_DATA;
            idx      <= '0;
            bus_idle <= 1'b0;
          end
        end
        ST_DATA: if (mid) begin
          sh  <= shift_in(sh, line, cfg_msb_first);
          idx <= idx + 1'b1;
          if (idx == last_idx) state <= has_extra ? ST_EXTRA : ST_STOP1;
        end
        ST_EXTRA: if (mid) begin
          extra <= line;
          state <= ST_STOP1;
        end
        ST_STOP1: if (mid) begin
          rx_full      <= 1'b1;
          rx_data      <= word;
          rx_addr_flag <= cfg_mp_mode & extra;
          err_parity   <= !cfg_mp_mode && cfg_par_en &&
                          (extra != parity_bit(word, cfg_par_odd));
          err_frame    <= !line;
          if (cfg_two_stop) state <= ST_STOP2;
          else begin
            bus_idle <= line;
            state    <= ST_IDLE;
          end
        end
        ST_STOP2: if (mid) begin
          err_frame <= err_frame | !line;
          bus_idle  <= line;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_full |=> rx_full);
  // R7
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !set_full) |=> !rx_full);
  // R2
  glitch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> (state == ST_IDLE && $stable(bus_idle) && !$rose(rx_full)));
  // R8
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(last_stop_pass));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> !bus_idle);
  // R3
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && !cfg_eight) |=> (rx_data[7] == 1'b0));
  // R5
  mp_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && cfg_mp_mode) |=> !err_parity);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cfg_eight,
  input  logic       cfg_msb_first,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_mp_mode,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_addr_flag,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       bus_idle
);
  logic line, fall, mid, run, restart;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
  );

  rx_os_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .run(run),
    .restart(restart), .mid(mid)
  );

  rx_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .line(line), .fall(fall), .mid(mid),
    .cfg_eight(cfg_eight), .cfg_msb_first(cfg_msb_first),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_mode(cfg_mp_mode),
    .rd_strobe(rd_strobe), .run(run), .restart(restart),
    .rx_data(rx_data), .rx_addr_flag(rx_addr_flag), .rx_full(rx_full),
    .err_parity(err_parity), .err_frame(err_frame), .bus_idle(bus_idle)
  );
endmodule

// File: tb/tb_serial_rx_frame.sv
module tb_serial_rx_frame;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic cfg_eight = 1'b1, cfg_msb_first = 1'b0, cfg_two_stop = 1'b0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_mode = 1'b0;
  logic rd_strobe;
  logic [7:0] rx_data;
  logic rx_addr_flag, rx_full, err_parity, err_frame, bus_idle;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       addr;
    logic       perr;
    logic       ferr;
    logic       idle;
    string      req;
  } exp_t;
  exp_t sb[$];

  serial_rx_frame dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_eight(cfg_eight), .cfg_msb_first(cfg_msb_first),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_mode(cfg_mp_mode),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_addr_flag(rx_addr_flag),
    .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
    .bus_idle(bus_idle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // Driver: computes the expected result, queues it, then drives the frame.
  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic addr_bit,
                            input logic bad_stop1, input logic bad_stop2, input string req);
    exp_t e;
    logic [7:0] w;
    int n;
    logic xb;
    n = cfg_eight ? 8 : 7;
    w = cfg_eight ? d : {1'b0, d[6:0]};
    xb = cfg_mp_mode ? addr_bit : ((^w) ^ cfg_par_odd ^ flip_par);
    e.data = w;
    e.addr = cfg_mp_mode & addr_bit;
    e.perr = !cfg_mp_mode && cfg_par_en && flip_par;
    e.ferr = bad_stop1;
    e.idle = !cfg_two_stop && !bad_stop1;
    e.req  = req;
    sb.push_back(e);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < n; i++)
      hold_line(cfg_msb_first ? w[n-1-i] : w[i], BIT_CLKS);
    if (cfg_mp_mode || cfg_par_en) hold_line(xb, BIT_CLKS);
    hold_line(!bad_stop1, BIT_CLKS);
    if (cfg_two_stop) hold_line(!bad_stop2, BIT_CLKS);
    hold_line(1'b1, 2 * BIT_CLKS);
  endtask

  // Monitor: pops the scoreboard on each full flag, compares, then reads.
  initial begin
    exp_t e;
    rd_strobe = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_full) begin
        if (sb.size() == 0) chk(1'b0, "R7 unexpected full", 8'd1, 8'd0);
        else begin
          e = sb.pop_front();
          chk(rx_data == e.data, {e.req, " data R3"}, rx_data, e.data);
          chk(rx_addr_flag == e.addr, {e.req, " addr R5"}, 8'(rx_addr_flag), 8'(e.addr));
          chk(err_parity == e.perr, {e.req, " parity R4"}, 8'(err_parity), 8'(e.perr));
          chk(err_frame == e.ferr, {e.req, " frame R6"}, 8'(err_frame), 8'(e.ferr));
          chk(bus_idle == e.idle, {e.req, " idle at full R8"}, 8'(bus_idle), 8'(e.idle));
        end
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        chk(!rx_full, "R7 read clears full", 8'(rx_full), 8'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!rx_full && !err_parity && !err_frame, "R9 flags", {5'd0, rx_full, err_parity, err_frame}, 8'd0);
    chk(rx_data == 8'd0, "R9 data", rx_data, 8'd0);
    chk(bus_idle, "R9 bus_idle", 8'(bus_idle), 8'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 8 bits, LSB first, one stop
    send_frame(8'hA5, 0, 0, 0, 0, "R1 8N1 lsb");
    send_frame(8'h3C, 0, 0, 0, 0, "R3 8N1 lsb");
    cfg_msb_first = 1'b1;
    send_frame(8'h81, 0, 0, 0, 0, "R3 8N1 msb");
    send_frame(8'h3C, 0, 0, 0, 0, "R3 8N1 msb b");
    // R3 7-bit, top bit of stimulus set must not appear
    cfg_eight = 1'b0; cfg_msb_first = 1'b0;
    send_frame(8'hC5, 0, 0, 0, 0, "R3 7N1 lsb");
    cfg_msb_first = 1'b1;
    send_frame(8'hC5, 0, 0, 0, 0, "R3 7N1 msb");
    // R4 parity, even then odd, with and without corruption
    cfg_par_en = 1'b1; cfg_msb_first = 1'b0;
    send_frame(8'h55, 0, 0, 0, 0, "R4 7E1 ok");
    send_frame(8'h55, 1, 0, 0, 0, "R4 7E1 bad");
    cfg_eight = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    send_frame(8'h07, 0, 0, 0, 0, "R4 8O2 ok");
    chk(bus_idle, "R8 idle after second stop", 8'(bus_idle), 8'd1);
    send_frame(8'h07, 1, 0, 0, 0, "R4 8O2 bad");
    // R5 multiprocessor mode: marker 1 and 0, parity never flagged
    cfg_mp_mode = 1'b1;
    send_frame(8'hF0, 1, 1, 0, 0, "R5 addr");
    send_frame(8'h0F, 1, 0, 0, 0, "R5 data");
    // R6 second stop low: err_frame rises after full, bus_idle stays low
    cfg_mp_mode = 1'b0; cfg_par_en = 1'b0;
    send_frame(8'h5A, 0, 0, 0, 1, "R6 bad stop2");
    chk(err_frame, "R6 err after second stop", 8'(err_frame), 8'd1);
    chk(!bus_idle, "R8 no idle after bad stop2", 8'(bus_idle), 8'd0);
    // R6 first stop low, one stop bit
    cfg_two_stop = 1'b0;
    send_frame(8'hC3, 0, 0, 1, 0, "R6 bad stop1");
    chk(!bus_idle, "R8 no idle after bad stop1", 8'(bus_idle), 8'd0);
    send_frame(8'h96, 0, 0, 0, 0, "R6 recover");
    chk(!err_frame && bus_idle, "R6 R8 recover", {6'd0, err_frame, bus_idle}, 8'd1);
    // R2 short start glitch (3 ticks) is ignored
    hold_line(1'b0, 6);
    hold_line(1'b1, 3 * BIT_CLKS);
    chk(!rx_full, "R2 no full on glitch", 8'(rx_full), 8'd0);
    chk(bus_idle, "R2 bus_idle kept", 8'(bus_idle), 8'd1);
    send_frame(8'h69, 0, 0, 0, 0, "R2 after glitch");

    repeat (8) @(negedge clk);
    chk(sb.size() == 0, "R7 all frames reported", 8'(sb.size()), 8'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule